// File: doc/BRIEF.md
# Coherence Cache Node Agent

This block is the per-node controller for a single tracked address in a small directory-based invalidation protocol. It holds one line in one of three states (invalid, shared, exclusive) together with that line's data word. It talks to the home directory over three one-entry message slots, each made of a command field and a data field:

- an outbound request slot, which carries share or exclusive requests;
- an inbound slot, which carries grants and invalidations;
- an outbound acknowledgement slot, which returns the line data to home when the line is invalidated.

Each slot uses a valid/ready handshake. The local side can ask for a share or an exclusive copy. It can also store a new value into the line, but only while the line is exclusive. Every accepted store is echoed one cycle later as a latest-data report, which a scoreboard or checker can follow.

At most one protocol action fires in a cycle. An inbound grant or invalidation wins over a store, and a store wins over a new request. Each action computes its effects from the state as it stood before the action. The outbound slots drain independently of the actions, whenever home raises ready.

Top module: `coh_node_agent`

## Requirements
- R1: After reset the line is invalid with data zero, both outbound slots are empty (valid 0, command 0), and the latest-data report is idle.
- R2: Line state encodes invalid=0, shared=1, exclusive=2. Message commands encode empty=0, share request=1, exclusive request=2, invalidate=3, invalidate acknowledge=4, share grant=5, exclusive grant=6.
- R3: A local share request is accepted (lreq_ready_o high) only when the line is invalid and the request slot is empty. The next cycle the request slot is valid with command 1.
- R4: A local exclusive request is accepted when the line is not exclusive and the request slot is empty. The next cycle the request slot holds command 2. When both local requests are raised together, the exclusive request is sent.
- R5: A full request slot keeps its command until home raises req_ready_o's partner req_ready_i. It is empty (valid 0, command 0) the cycle after that handshake.
- R6: An inbound share grant (command 5) is always accepted. The line becomes shared and takes the grant's data.
- R7: An inbound exclusive grant (command 6) is always accepted. The line becomes exclusive and takes the grant's data.
- R8: An inbound invalidate (command 3) is accepted only while the acknowledgement slot is empty. Accepting it makes the line invalid with data zero, and fills the acknowledgement slot with command 4 and the line's previous data. While the acknowledgement slot is full, the invalidate is left waiting and the line is unchanged.
- R9: A local store is accepted only while the line is exclusive. It replaces the line data, and one cycle later latest_valid_o pulses once with the stored value. In other states the store is refused and the data is unchanged.
- R10: At most one of gnt_ready_o, store_ready_o and lreq_ready_o is high in a cycle. An acceptable inbound message takes precedence over a store or a request raised in the same cycle.
- R11: An inbound message whose command is not 3, 5 or 6 is not accepted and changes nothing.
- R12: A full acknowledgement slot keeps its command and data until ack_ready_i is high. It is empty the cycle after that handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lreq_shr_i | input | 1 | Local wish for a shared copy |
| lreq_exc_i | input | 1 | Local wish for an exclusive copy |
| lreq_ready_o | output | 1 | A request is loaded into the request slot this cycle |
| store_valid_i | input | 1 | Local store offered |
| store_data_i | input | DW | Store value |
| store_ready_o | output | 1 | Store accepted this cycle |
| gnt_valid_i | input | 1 | Inbound slot holds a message |
| gnt_cmd_i | input | 3 | Inbound command |
| gnt_data_i | input | DW | Inbound data |
| gnt_ready_o | output | 1 | Inbound message consumed this cycle |
| req_valid_o | output | 1 | Request slot full |
| req_cmd_o | output | 3 | Request slot command |
| req_data_o | output | DW | Request slot data (always zero) |
| req_ready_i | input | 1 | Home takes the request |
| ack_valid_o | output | 1 | Acknowledgement slot full |
| ack_cmd_o | output | 3 | Acknowledgement slot command |
| ack_data_o | output | DW | Line data returned to home |
| ack_ready_i | input | 1 | Home takes the acknowledgement |
| line_state_o | output | 2 | Current line state |
| line_data_o | output | DW | Current line data |
| latest_valid_o | output | 1 | One-cycle pulse after an accepted store |
| latest_data_o | output | DW | Value of the last accepted store |

## Verification
The bench builds the agent with an 8-bit data word, the exclusive-first choice for simultaneous local requests, and data clearing on invalidation. An 8-bit word is wide enough that the stored, granted and returned values (0x3C, 0x5A, 0x77) stay distinct. That makes it visible which value landed in the line and which value went back in an acknowledgement. Keeping the exclusive-first and data-clearing variants puts two corner cases within reach: the tie between the two local requests, and the zero data an invalidated line must show.

// File: rtl/coh_node_pkg.sv
package coh_node_pkg;

   localparam int CMD_W = 3;
   localparam int ST_W  = 2;

   typedef enum logic [ST_W-1:0] {
      LN_INV = 2'd0,
      LN_SHR = 2'd1,
      LN_EXC = 2'd2
   } line_st_e;

   typedef enum logic [CMD_W-1:0] {
      MC_EMPTY = 3'd0,
      MC_RQS   = 3'd1,
      MC_RQE   = 3'd2,
      MC_INV   = 3'd3,
      MC_IACK  = 3'd4,
      MC_GNTS  = 3'd5,
      MC_GNTE  = 3'd6
   } msg_cmd_e;

endpackage

// File: rtl/coh_out_slot.sv
module coh_out_slot
   import coh_node_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CMD_W-1:0] load_cmd_i,
   input  logic [DW-1:0]    load_data_i,
   input  logic             ready_i,
   output logic             full_o,
   output logic [CMD_W-1:0] cmd_o,
   output logic [DW-1:0]    data_o
);

   logic             full_q;
   logic [CMD_W-1:0] cmd_q;
   logic [DW-1:0]    data_q;

   // A load only happens while the slot is empty, so load and drain never collide.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full_q <= 1'b0;
         cmd_q  <= MC_EMPTY;
         data_q <= '0;
      end else if (load_i) begin
         full_q <= 1'b1;
         cmd_q  <= load_cmd_i;
         data_q <= load_data_i;
      end else if (full_q && ready_i) begin
         full_q <= 1'b0;
         cmd_q  <= MC_EMPTY;
         data_q <= '0;
      end
   end

   assign full_o = full_q;
   assign cmd_o  = cmd_q;
   assign data_o = data_q;

endmodule

// File: rtl/coh_act_arb.sv
module coh_act_arb
   import coh_node_pkg::*;
#(
   parameter bit PREFER_EXCL = 1'b1
) (
   input  logic [ST_W-1:0]  line_st_i,
   input  logic             req_full_i,
   input  logic             ack_full_i,
   input  logic             gnt_valid_i,
   input  logic [CMD_W-1:0] gnt_cmd_i,
   input  logic             store_valid_i,
   input  logic             want_shr_i,
   input  logic             want_exc_i,
   output logic             take_gnt_o,
   output logic             take_store_o,
   output logic             take_req_o,
   output logic [CMD_W-1:0] req_cmd_o
);

   logic gnt_ok;
   logic shr_ok;
   logic exc_ok;

   always_comb begin
      unique case (msg_cmd_e'(gnt_cmd_i))
         MC_GNTS, MC_GNTE: gnt_ok = 1'b1;
         MC_INV:           gnt_ok = !ack_full_i;
         default:          gnt_ok = 1'b0;
      endcase
   end

   assign shr_ok = want_shr_i && (line_st_i == LN_INV) && !req_full_i;
   assign exc_ok = want_exc_i && (line_st_i != LN_EXC) && !req_full_i;

   // Priority: inbound message, then store, then new request.
   assign take_gnt_o   = gnt_valid_i && gnt_ok;
   assign take_store_o = !take_gnt_o && store_valid_i && (line_st_i == LN_EXC);
   assign take_req_o   = !take_gnt_o && !take_store_o && (shr_ok || exc_ok);

   generate
      if (PREFER_EXCL) begin : g_excl_first
         assign req_cmd_o = exc_ok ? MC_RQE : MC_RQS;
      end else begin : g_shr_first
         assign req_cmd_o = shr_ok ? MC_RQS : MC_RQE;
      end
   endgenerate

endmodule

// File: rtl/coh_line_reg.sv
module coh_line_reg
   import coh_node_pkg::*;
#(
   parameter int DW           = 8,
   parameter bit CLEAR_ON_INV = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take_gnt_i,
   input  logic [CMD_W-1:0] gnt_cmd_i,
   input  logic [DW-1:0]    gnt_data_i,
   input  logic             take_store_i,
   input  logic [DW-1:0]    store_data_i,
   output logic [ST_W-1:0]  state_o,
   output logic [DW-1:0]    data_o,
   output logic             latest_valid_o,
   output logic [DW-1:0]    latest_data_o
);

   line_st_e      st_q;
   logic [DW-1:0] data_q;
   logic [DW-1:0] inv_fill;
   logic          lat_v_q;
   logic [DW-1:0] lat_d_q;

   generate
      if (CLEAR_ON_INV) begin : g_clear
         assign inv_fill = '0;
      end else begin : g_keep
         assign inv_fill = data_q;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= LN_INV;
         data_q  <= '0;
         lat_v_q <= 1'b0;
         lat_d_q <= '0;
      end else begin
         lat_v_q <= take_store_i;
         if (take_store_i) lat_d_q <= store_data_i;
         if (take_gnt_i) begin
            case (msg_cmd_e'(gnt_cmd_i))
               MC_GNTS: begin
                  st_q   <= LN_SHR;
                  data_q <= gnt_data_i;
               end
               MC_GNTE: begin
                  st_q   <= LN_EXC;
                  data_q <= gnt_data_i;
               end
               MC_INV: begin
                  st_q   <= LN_INV;
                  data_q <= inv_fill;
               end
               default: ;
            endcase
         end else if (take_store_i) begin
            data_q <= store_data_i;
         end
      end
   end

   assign state_o        = st_q;
   assign data_o         = data_q;
   assign latest_valid_o = lat_v_q;
   assign latest_data_o  = lat_d_q;

endmodule

// File: rtl/coh_node_agent.sv
module coh_node_agent
   import coh_node_pkg::*;
#(
   parameter int DW           = 8,
   parameter bit PREFER_EXCL  = 1'b1,
   parameter bit CLEAR_ON_INV = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          lreq_shr_i,
   input  logic          lreq_exc_i,
   output logic          lreq_ready_o,
   input  logic          store_valid_i,
   input  logic [DW-1:0] store_data_i,
   output logic          store_ready_o,
   input  logic          gnt_valid_i,
   input  logic [2:0]    gnt_cmd_i,
   input  logic [DW-1:0] gnt_data_i,
   output logic          gnt_ready_o,
   output logic          req_valid_o,
   output logic [2:0]    req_cmd_o,
   output logic [DW-1:0] req_data_o,
   input  logic          req_ready_i,
   output logic          ack_valid_o,
   output logic [2:0]    ack_cmd_o,
   output logic [DW-1:0] ack_data_o,
   input  logic          ack_ready_i,
   output logic [1:0]    line_state_o,
   output logic [DW-1:0] line_data_o,
   output logic          latest_valid_o,
   output logic [DW-1:0] latest_data_o
);

   generate
      if (DW < 1 || DW > 1024) begin : g_bad_dw
         $error("coh_node_agent: DW out of range");
      end
   endgenerate

   logic             take_gnt;
   logic             take_store;
   logic             take_req;
   logic [CMD_W-1:0] new_req_cmd;
   logic             req_full;
   logic             ack_full;
   logic             ack_load;
   logic [ST_W-1:0]  st;
   logic [DW-1:0]    ldata;

   coh_act_arb #(.PREFER_EXCL(PREFER_EXCL)) u_arb (
      .line_st_i     (st),
      .req_full_i    (req_full),
      .ack_full_i    (ack_full),
      .gnt_valid_i   (gnt_valid_i),
      .gnt_cmd_i     (gnt_cmd_i),
      .store_valid_i (store_valid_i),
      .want_shr_i    (lreq_shr_i),
      .want_exc_i    (lreq_exc_i),
      .take_gnt_o    (take_gnt),
      .take_store_o  (take_store),
      .take_req_o    (take_req),
      .req_cmd_o     (new_req_cmd)
   );

   coh_line_reg #(.DW(DW), .CLEAR_ON_INV(CLEAR_ON_INV)) u_line (
      .clk            (clk),
      .rst_n          (rst_n),
      .take_gnt_i     (take_gnt),
      .gnt_cmd_i      (gnt_cmd_i),
      .gnt_data_i     (gnt_data_i),
      .take_store_i   (take_store),
      .store_data_i   (store_data_i),
      .state_o        (st),
      .data_o         (ldata),
      .latest_valid_o (latest_valid_o),
      .latest_data_o  (latest_data_o)
   );

   coh_out_slot #(.DW(DW)) u_req_slot (
      .clk         (clk),
      .rst_n       (rst_n),
      .load_i      (take_req),
      .load_cmd_i  (new_req_cmd),
      .load_data_i ('0),
      .ready_i     (req_ready_i),
      .full_o      (req_full),
      .cmd_o       (req_cmd_o),
      .data_o      (req_data_o)
   );

   // The acknowledgement carries the line data as it stood before the invalidation.
   assign ack_load = take_gnt && (gnt_cmd_i == MC_INV);

   coh_out_slot #(.DW(DW)) u_ack_slot (
      .clk         (clk),
      .rst_n       (rst_n),
      .load_i      (ack_load),
      .load_cmd_i  (MC_IACK),
      .load_data_i (ldata),
      .ready_i     (ack_ready_i),
      .full_o      (ack_full),
      .cmd_o       (ack_cmd_o),
      .data_o      (ack_data_o)
   );

   assign lreq_ready_o  = take_req;
   assign store_ready_o = take_store;
   assign gnt_ready_o   = take_gnt;
   assign req_valid_o   = req_full;
   assign ack_valid_o   = ack_full;
   assign line_state_o  = st;
   assign line_data_o   = ldata;

endmodule

// File: rtl/coh_node_agent_chk.sv
module coh_node_agent_chk #(
   parameter int DW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          lreq_shr_i,
   input logic          lreq_exc_i,
   input logic          lreq_ready_o,
   input logic          store_valid_i,
   input logic [DW-1:0] store_data_i,
   input logic          store_ready_o,
   input logic          gnt_valid_i,
   input logic [2:0]    gnt_cmd_i,
   input logic [DW-1:0] gnt_data_i,
   input logic          gnt_ready_o,
   input logic          req_valid_o,
   input logic [2:0]    req_cmd_o,
   input logic [DW-1:0] req_data_o,
   input logic          req_ready_i,
   input logic          ack_valid_o,
   input logic [2:0]    ack_cmd_o,
   input logic [DW-1:0] ack_data_o,
   input logic          ack_ready_i,
   input logic [1:0]    line_state_o,
   input logic [DW-1:0] line_data_o,
   input logic          latest_valid_o,
   input logic [DW-1:0] latest_data_o
);

   a_r2_state_legal: assert property (@(posedge clk) disable iff (!rst_n)
      line_state_o != 2'd3);

   a_r3_share_from_invalid: assert property (@(posedge clk) disable iff (!rst_n)
      (lreq_ready_o && lreq_shr_i && !lreq_exc_i) |-> (line_state_o == 2'd0));

   a_r4_excl_request_sent: assert property (@(posedge clk) disable iff (!rst_n)
      (lreq_ready_o && lreq_exc_i && !lreq_shr_i) |=> (req_valid_o && req_cmd_o == 3'd2));

   a_r5_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid_o && !req_ready_i) |=> (req_valid_o && $stable(req_cmd_o) && $stable(req_data_o)));

   a_r6_share_grant: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_ready_o && gnt_cmd_i == 3'd5) |=> (line_state_o == 2'd1 && line_data_o == $past(gnt_data_i)));

   a_r7_excl_grant: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_ready_o && gnt_cmd_i == 3'd6) |=> (line_state_o == 2'd2 && line_data_o == $past(gnt_data_i)));

   a_r8_inv_waits: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_valid_i && gnt_cmd_i == 3'd3 && ack_valid_o) |-> !gnt_ready_o);

   a_r8_inv_acked: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_ready_o && gnt_cmd_i == 3'd3) |=>
      (line_state_o == 2'd0 && ack_valid_o && ack_cmd_o == 3'd4 && ack_data_o == $past(line_data_o)));

   a_r9_store_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      store_ready_o |-> (line_state_o == 2'd2));

   a_r9_latest_report: assert property (@(posedge clk) disable iff (!rst_n)
      store_ready_o |=> (latest_valid_o && latest_data_o == $past(store_data_i)));

   a_r10_one_action: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({gnt_ready_o, store_ready_o, lreq_ready_o}) <= 1);

   a_r10_grant_first: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_valid_i && (gnt_cmd_i == 3'd5 || gnt_cmd_i == 3'd6)) |-> gnt_ready_o);

   a_r11_other_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_valid_i && gnt_cmd_i != 3'd3 && gnt_cmd_i != 3'd5 && gnt_cmd_i != 3'd6) |-> !gnt_ready_o);

   a_r12_ack_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_valid_o && !ack_ready_i) |=> (ack_valid_o && $stable(ack_cmd_o) && $stable(ack_data_o)));

endmodule

bind coh_node_agent coh_node_agent_chk #(.DW(DW)) u_chk (.*);

// File: tb/tb_coh_node_agent.sv
module tb_coh_node_agent;

   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          lreq_shr_i = 1'b0, lreq_exc_i = 1'b0, lreq_ready_o;
   logic          store_valid_i = 1'b0, store_ready_o;
   logic [DW-1:0] store_data_i = '0;
   logic          gnt_valid_i = 1'b0, gnt_ready_o;
   logic [2:0]    gnt_cmd_i = '0;
   logic [DW-1:0] gnt_data_i = '0;
   logic          req_valid_o, req_ready_i = 1'b0;
   logic [2:0]    req_cmd_o;
   logic [DW-1:0] req_data_o;
   logic          ack_valid_o, ack_ready_i = 1'b0;
   logic [2:0]    ack_cmd_o;
   logic [DW-1:0] ack_data_o;
   logic [1:0]    line_state_o;
   logic [DW-1:0] line_data_o;
   logic          latest_valid_o;
   logic [DW-1:0] latest_data_o;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   coh_node_agent #(.DW(DW)) dut (.*);

   typedef struct packed {
      logic       rs, re, sv;
      logic [7:0] sd;
      logic       gv;
      logic [2:0] gc;
      logic [7:0] gd;
      logic       qr, ar;
      logic [2:0] xr;   // {gnt_ready, store_ready, lreq_ready} before the edge
      logic [1:0] xs;
      logic [7:0] xd;
      logic       xqv;
      logic [2:0] xqc;
      logic       xav;
      logic [2:0] xac;
      logic [7:0] xad;
      logic [7:0] tag;
   } vec_t;

   localparam int NV = 16;
   localparam vec_t VEC [NV] = '{
      // R1 idle after reset
      '{1'b0,1'b0,1'b0,8'h00,1'b0,3'd0,8'h00,1'b0,1'b0,3'b000,2'd0,8'h00,1'b0,3'd0,1'b0,3'd0,8'h00,8'd1},
      // R9 store refused while invalid
      '{1'b0,1'b0,1'b1,8'hAA,1'b0,3'd0,8'h00,1'b0,1'b0,3'b000,2'd0,8'h00,1'b0,3'd0,1'b0,3'd0,8'h00,8'd9},
      // R3 share request from invalid
      '{1'b1,1'b0,1'b0,8'h00,1'b0,3'd0,8'h00,1'b0,1'b0,3'b001,2'd0,8'h00,1'b1,3'd1,1'b0,3'd0,8'h00,8'd3},
      // R5 slot full, request refused and held
      '{1'b1,1'b0,1'b0,8'h00,1'b0,3'd0,8'h00,1'b0,1'b0,3'b000,2'd0,8'h00,1'b1,3'd1,1'b0,3'd0,8'h00,8'd5},
      // R5 drain
      '{1'b0,1'b0,1'b0,8'h00,1'b0,3'd0,8'h00,1'b1,1'b0,3'b000,2'd0,8'h00,1'b0,3'd0,1'b0,3'd0,8'h00,8'd5},
      // R6 share grant
      '{1'b0,1'b0,1'b0,8'h00,1'b1,3'd5,8'h3C,1'b0,1'b0,3'b100,2'd1,8'h3C,1'b0,3'd0,1'b0,3'd0,8'h00,8'd6},
      // R3 share request refused while shared
      '{1'b1,1'b0,1'b0,8'h00,1'b0,3'd0,8'h00,1'b0,1'b0,3'b000,2'd1,8'h3C,1'b0,3'd0,1'b0,3'd0,8'h00,8'd3},
      // R4 exclusive request from shared
      '{1'b0,1'b1,1'b0,8'h00,1'b0,3'd0,8'h00,1'b0,1'b0,3'b001,2'd1,8'h3C,1'b1,3'd2,1'b0,3'd0,8'h00,8'd4},
      // R7 exclusive grant with concurrent drain
      '{1'b0,1'b0,1'b0,8'h00,1'b1,3'd6,8'h5A,1'b1,1'b0,3'b100,2'd2,8'h5A,1'b0,3'd0,1'b0,3'd0,8'h00,8'd7},
      // R9 store in exclusive, exclusive request not enabled
      '{1'b0,1'b1,1'b1,8'h77,1'b0,3'd0,8'h00,1'b0,1'b0,3'b010,2'd2,8'h77,1'b0,3'd0,1'b0,3'd0,8'h00,8'd9},
      // R10 invalidate beats store
      '{1'b0,1'b0,1'b1,8'h11,1'b1,3'd3,8'h00,1'b0,1'b0,3'b100,2'd0,8'h00,1'b0,3'd0,1'b1,3'd4,8'h77,8'd10},
      // R8 invalidate waits on full ack slot; request goes instead
      '{1'b1,1'b0,1'b0,8'h00,1'b1,3'd3,8'h00,1'b0,1'b0,3'b001,2'd0,8'h00,1'b1,3'd1,1'b1,3'd4,8'h77,8'd8},
      // R12 both slots drain, invalidate still waits this cycle
      '{1'b0,1'b0,1'b0,8'h00,1'b1,3'd3,8'h00,1'b1,1'b1,3'b000,2'd0,8'h00,1'b0,3'd0,1'b0,3'd0,8'h00,8'd12},
      // R8 invalidate of an invalid line
      '{1'b0,1'b0,1'b0,8'h00,1'b1,3'd3,8'h00,1'b0,1'b0,3'b100,2'd0,8'h00,1'b0,3'd0,1'b1,3'd4,8'h00,8'd8},
      // R11 illegal inbound command ignored
      '{1'b0,1'b0,1'b0,8'h00,1'b1,3'd1,8'h99,1'b0,1'b1,3'b000,2'd0,8'h00,1'b0,3'd0,1'b0,3'd0,8'h00,8'd11},
      // R4 both local requests: exclusive sent
      '{1'b1,1'b1,1'b0,8'h00,1'b0,3'd0,8'h00,1'b0,1'b0,3'b001,2'd0,8'h00,1'b1,3'd2,1'b0,3'd0,8'h00,8'd4}
   };

   task automatic check(input int rq, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL R%0d %s actual=%0h expected=%0h", rq, what, act, exp);
      end
   endtask

   task automatic idle_inputs();
      lreq_shr_i = 0; lreq_exc_i = 0; store_valid_i = 0; store_data_i = '0;
      gnt_valid_i = 0; gnt_cmd_i = '0; gnt_data_i = '0; req_ready_i = 0; ack_ready_i = 0;
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired actual=running expected=finished");
         finish_run();
      end
   end

   initial begin
      idle_inputs();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check(1, "reset state", {30'd0, line_state_o}, 32'd0);
      check(1, "reset data", {24'd0, line_data_o}, 32'd0);
      check(1, "reset req slot", {28'd0, req_valid_o, req_cmd_o}, 32'd0);
      check(1, "reset ack slot", {28'd0, ack_valid_o, ack_cmd_o}, 32'd0);
      check(1, "reset latest", {31'd0, latest_valid_o}, 32'd0);

      // Table walk; R2 encodings are used throughout
      for (int i = 0; i < NV; i++) begin
         lreq_shr_i = VEC[i].rs; lreq_exc_i = VEC[i].re;
         store_valid_i = VEC[i].sv; store_data_i = VEC[i].sd;
         gnt_valid_i = VEC[i].gv; gnt_cmd_i = VEC[i].gc; gnt_data_i = VEC[i].gd;
         req_ready_i = VEC[i].qr; ack_ready_i = VEC[i].ar;
         #1;
         check(VEC[i].tag, $sformatf("v%0d readies", i),
               {29'd0, gnt_ready_o, store_ready_o, lreq_ready_o}, {29'd0, VEC[i].xr});
         @(negedge clk);
         check(VEC[i].tag, $sformatf("v%0d state", i), {30'd0, line_state_o}, {30'd0, VEC[i].xs});
         check(VEC[i].tag, $sformatf("v%0d data", i), {24'd0, line_data_o}, {24'd0, VEC[i].xd});
         check(VEC[i].tag, $sformatf("v%0d req slot", i),
               {28'd0, req_valid_o, req_cmd_o}, {28'd0, VEC[i].xqv, VEC[i].xqc});
         check(VEC[i].tag, $sformatf("v%0d ack slot", i),
               {20'd0, ack_valid_o, ack_cmd_o, ack_data_o}, {20'd0, VEC[i].xav, VEC[i].xac, VEC[i].xad});
      end

      // R9 latest-data pulse: reach exclusive, store, observe one pulse
      idle_inputs();
      gnt_valid_i = 1; gnt_cmd_i = 3'd6; gnt_data_i = 8'h42; req_ready_i = 1;
      @(negedge clk);
      idle_inputs();
      store_valid_i = 1; store_data_i = 8'h99;
      @(negedge clk);
      idle_inputs();
      check(9, "latest pulse", {31'd0, latest_valid_o}, 32'd1);
      check(9, "latest value", {24'd0, latest_data_o}, 32'h99);
      check(9, "stored line data", {24'd0, line_data_o}, 32'h99);
      @(negedge clk);
      check(9, "latest pulse ends", {31'd0, latest_valid_o}, 32'd0);

      // R10 share grant and share request together in invalid
      gnt_valid_i = 1; gnt_cmd_i = 3'd3;
      @(negedge clk);
      idle_inputs();
      ack_ready_i = 1;
      @(negedge clk);
      idle_inputs();
      lreq_shr_i = 1; gnt_valid_i = 1; gnt_cmd_i = 3'd5; gnt_data_i = 8'h21;
      #1;
      check(10, "grant over request", {30'd0, gnt_ready_o, lreq_ready_o}, 32'b10);
      @(negedge clk);
      idle_inputs();
      check(10, "no request sent", {31'd0, req_valid_o}, 32'd0);
      check(6, "shared after grant", {22'd0, line_state_o, line_data_o}, {22'd0, 2'd1, 8'h21});

      // R1 reset mid-operation with the ack slot full
      gnt_valid_i = 1; gnt_cmd_i = 3'd3;
      @(negedge clk);
      idle_inputs();
      check(8, "ack before reset", {28'd0, ack_valid_o, ack_cmd_o}, {28'd0, 1'b1, 3'd4});
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(1, "reset clears ack", {28'd0, ack_valid_o, ack_cmd_o}, 32'd0);
      check(1, "reset state again", {22'd0, line_state_o, line_data_o}, 32'd0);

      finish_run();
   end

endmodule